// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Status Flags and Branch Condition Check

This block is the arithmetic slice of a small integer core. It adds or subtracts two operands, or shifts one operand left or right with a carry-out. It also performs two compare forms. One subtracts and the other adds, and both keep only the flags. The result and its write strobe are combinational. The four status flags (negative, zero, carry, overflow) are held in a register. That register loads on a clock edge only when the caller asks for a flag update.

A second path judges branches. It takes a 4-bit condition code and tests it against the stored flags. It does not test the operation currently on the inputs. A branch therefore follows the last flag-setting operation. A compare followed by a conditional branch on the next cycle is the intended pattern.

Top module: `alu_flag_unit`

## Requirements
- R1: Op code 0 (add) drives `result` = (a + b) mod 2^32 with `result_wr` high. The carry flag becomes 1 exactly when the unsigned sum is at least 2^32.
- R2: Op code 1 (subtract) drives `result` = (a - b) mod 2^32 with `result_wr` high. The carry flag becomes 1 when no borrow occurs (a >= b unsigned) and 0 otherwise.
- R3: The overflow flag is set on add when both operands have the same sign and the sum has the other sign. On subtract it is set when a negative minus a positive gives a positive, or a positive minus a negative gives a negative. Otherwise it is cleared.
- R4: The negative flag copies result bit 31, and the zero flag is 1 when all 32 result bits are 0. The `nzcv` port packs the flags as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V.
- R5: Op code 2 (compare) sets the flags as a subtract would, and op code 3 (compare-negative) sets them as an add would. Both hold `result` at 0 with `result_wr` low.
- R6: Op codes 4 (shift left) and 5 (logical shift right) shift `opnd_a` by `opnd_b[4:0]` places, with `result_wr` high. C takes the last bit shifted out. A shift of 0 places keeps C, and every shift keeps V.
- R7: The flags change only on a rising clock edge where `set_flags` is high. A synchronous active-low reset clears them to 0000.
- R8: Op codes 6 and 7 are no-operations. They drive `result` at 0 and `result_wr` low, and they leave the flags unchanged even when `set_flags` is high.
- R9: `br_taken` decodes `cond` as follows:
  - 0 when Z=1, and 1 when Z=0.
  - 2 when C=1, and 3 when C=0.
  - 4 when N=1, and 5 when N=0.
  - 6 when V=1, and 7 when V=0.
  - 8 when C=1 and Z=0, and 9 when C=0 or Z=1.
  - 10 when N=V, and 11 when N!=V.
  - 12 when Z=0 and N=V, and 13 when Z=1 or N!=V.
  - 14 is always taken, and 15 is never taken.
- R10: `br_taken` is combinational in `cond` and reads only the stored flags. The operation on the inputs in the same cycle has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 cmp, 3 cmn, 4 shl, 5 shr, 6-7 none) |
| opnd_a | input | 32 | First operand / value to shift |
| opnd_b | input | 32 | Second operand / shift amount in bits 4:0 |
| set_flags | input | 1 | Load the flag register at the next edge |
| cond | input | 4 | Branch condition code |
| result | output | 32 | Operation result for register write |
| result_wr | output | 1 | Result is to be written |
| nzcv | output | 4 | Stored flags N, Z, C, V (bits 3..0) |
| br_taken | output | 1 | Condition met by stored flags |

## Verification
`result` and `result_wr` settle in the same cycle as the operands. The bench drives on the falling edge and reads them a few nanoseconds later, before the next rising edge. `nzcv` reflects an operation one rising edge after it was presented with `set_flags` high. The bench therefore reads the flags just after that edge. `br_taken` is combinational from `cond` and the stored flags, so every condition code is swept within the cycle that follows each flag load. Each condition is read a short delay after it is driven.

// File: rtl/alu_flag_pkg.sv
// Package: shared types for the flag unit.
// Assumes: op codes and condition codes are fixed 3-bit and 4-bit encodings.
package alu_flag_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_CMP = 3'd2,
        OP_CMN = 3'd3,
        OP_SHL = 3'd4,
        OP_SHR = 3'd5,
        OP_NO6 = 3'd6,
        OP_NO7 = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/alu_addsub.sv
// Module: two's-complement adder/subtractor with carry and signed overflow.
// Assumes: sub=1 computes a-b as a + ~b + 1, so carry out means "no borrow".
module alu_addsub #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] sum,
    output logic          c_out,
    output logic          v_out
);
    logic [DW-1:0] b_eff;
    logic [DW:0]   wide;

    // Invert b and inject a carry for subtraction, then form the wide sum.
    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, sub};
        sum   = wide[DW-1:0];
        c_out = wide[DW];
        v_out = (a[DW-1] == b_eff[DW-1]) && (wide[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/alu_shift.sv
// Module: logical left/right shifter reporting the last bit shifted out.
// Assumes: a shift amount of zero shifts nothing and reports no carry.
module alu_shift #(
    parameter int DW  = 32,
    parameter int SHW = $clog2(DW)
) (
    input  logic [DW-1:0]  a,
    input  logic [SHW-1:0] amt,
    input  logic           right,
    output logic [DW-1:0]  res,
    output logic           c_out,
    output logic           c_valid
);
    logic [DW:0] ext;

    // Shift in a one-bit-wider word so the spill bit is the carry.
    always_comb begin
        if (right) begin
            ext   = {a, 1'b0} >> amt;
            res   = ext[DW:1];
            c_out = ext[0];
        end else begin
            ext   = {1'b0, a} << amt;
            res   = ext[DW-1:0];
            c_out = ext[DW];
        end
        c_valid = (amt != '0);
    end
endmodule

// File: rtl/alu_flag_reg.sv
// Module: status flag register with load enable.
// Assumes: synchronous active-low reset; flags clear to all zero.
module alu_flag_reg
    import alu_flag_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   upd_en,
    input  flags_t nxt,
    output flags_t cur
);
    // Load new flags only when an update is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur <= '0;
        else if (upd_en) cur <= nxt;
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(cur));
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (cur == $past(nxt)));
    p_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cur == '0));
endmodule

// File: rtl/alu_cond_eval.sv
// Module: branch condition evaluator over stored flags.
// Assumes: code 14 is always true and code 15 is never true.
module alu_cond_eval
    import alu_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] cond,
    input  flags_t     fl,
    output logic       taken
);
    cond_e cc;
    logic  ge;

    // Decode the condition code against the stored flags.
    always_comb begin
        cc = cond_e'(cond);
        ge = (fl.n == fl.v);
        unique case (cc)
            CC_EQ: taken = fl.z;
            CC_NE: taken = !fl.z;
            CC_CS: taken = fl.c;
            CC_CC: taken = !fl.c;
            CC_MI: taken = fl.n;
            CC_PL: taken = !fl.n;
            CC_VS: taken = fl.v;
            CC_VC: taken = !fl.v;
            CC_HI: taken = fl.c && !fl.z;
            CC_LS: taken = !fl.c || fl.z;
            CC_GE: taken = ge;
            CC_LT: taken = !ge;
            CC_GT: taken = !fl.z && ge;
            CC_LE: taken = fl.z || !ge;
            CC_AL: taken = 1'b1;
            default: taken = 1'b0;
        endcase
    end

    p_always_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 4'd14) |-> taken);
    p_never_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 4'd15) |-> !taken);
    p_eq_ne_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond[3:1] == 3'd0) |-> (taken == (fl.z ^ cond[0])));
endmodule

// File: rtl/alu_flag_unit.sv
// Module: top of the add/subtract/shift unit with flag register and branch check.
// Assumes: result is combinational; flags load at the edge when set_flags is high;
//          br_taken sees only the registered flags.
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int DW  = 32,
    parameter int SHW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_sel,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          set_flags,
    input  logic [3:0]    cond,
    output logic [DW-1:0] result,
    output logic          result_wr,
    output logic [3:0]    nzcv,
    output logic          br_taken
);
    op_e           op;
    logic          do_sub;
    logic [DW-1:0] as_sum;
    logic          as_c, as_v;
    logic [DW-1:0] sh_res;
    logic          sh_c, sh_cv;
    logic [DW-1:0] raw;
    logic          ops_valid;
    flags_t        cur_fl, nxt_fl;

    assign op     = op_e'(op_sel);
    assign do_sub = (op == OP_SUB) || (op == OP_CMP);

    alu_addsub #(.DW(DW)) u_addsub (
        .a(opnd_a), .b(opnd_b), .sub(do_sub),
        .sum(as_sum), .c_out(as_c), .v_out(as_v)
    );

    alu_shift #(.DW(DW), .SHW(SHW)) u_shift (
        .a(opnd_a), .amt(opnd_b[SHW-1:0]), .right(op == OP_SHR),
        .res(sh_res), .c_out(sh_c), .c_valid(sh_cv)
    );

    // Select the raw value and next flags per operation.
    always_comb begin
        raw       = '0;
        ops_valid = 1'b1;
        nxt_fl    = cur_fl;
        result_wr = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                raw = as_sum; result_wr = 1'b1;
                nxt_fl.c = as_c; nxt_fl.v = as_v;
            end
            OP_CMP, OP_CMN: begin
                raw = as_sum;
                nxt_fl.c = as_c; nxt_fl.v = as_v;
            end
            OP_SHL, OP_SHR: begin
                raw = sh_res; result_wr = 1'b1;
                if (sh_cv) nxt_fl.c = sh_c;
            end
            default: ops_valid = 1'b0;
        endcase
        if (ops_valid) begin
            nxt_fl.n = raw[DW-1];
            nxt_fl.z = (raw == '0);
        end
    end

    // Drive the write path only for result-producing operations.
    always_comb result = result_wr ? raw : '0;

    alu_flag_reg u_flags (
        .clk(clk), .rst_n(rst_n), .upd_en(set_flags && ops_valid),
        .nxt(nxt_fl), .cur(cur_fl)
    );

    alu_cond_eval u_cond (
        .clk(clk), .rst_n(rst_n), .cond(cond), .fl(cur_fl), .taken(br_taken)
    );

    assign nzcv = cur_fl;

    p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_sel == 3'd2) || (op_sel == 3'd3)) |-> (!result_wr && result == '0));
    p_add_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd0 && set_flags) |=>
            (nzcv[1] == (({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)}) >> DW)));
    p_shift_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel[2:1] == 2'b10) |=> (nzcv[0] == $past(nzcv[0])));
    p_noop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel[2:1] == 2'b11) |=> $stable(nzcv));
endmodule

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        set_flags = 1'b0;
    logic [3:0]  cond = '0;
    logic [31:0] result;
    logic        result_wr;
    logic [3:0]  nzcv;
    logic        br_taken;
    int          n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    alu_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .set_flags(set_flags), .cond(cond), .result(result), .result_wr(result_wr),
        .nzcv(nzcv), .br_taken(br_taken)
    );

    // fields: op(3) a(32) b(32) result(32) wr(1) nzcv(4)
    localparam int NV = 20;
    localparam logic [103:0] VECS [0:NV-1] = '{
        {3'd0, 32'h00000001, 32'h00000001, 32'h00000002, 1'b1, 4'b0000}, // R1
        {3'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 4'b0110}, // R1 R4
        {3'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1, 4'b1001}, // R3
        {3'd0, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 4'b0111}, // R3
        {3'd1, 32'h00000005, 32'h00000003, 32'h00000002, 1'b1, 4'b0010}, // R2
        {3'd1, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 1'b1, 4'b1000}, // R2
        {3'd1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 4'b0011}, // R3
        {3'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 1'b1, 4'b1001}, // R3
        {3'd2, 32'h00000007, 32'h00000007, 32'h00000000, 1'b0, 4'b0110}, // R5
        {3'd3, 32'h00000005, 32'hFFFFFFFE, 32'h00000000, 1'b0, 4'b0010}, // R5
        {3'd4, 32'h40000000, 32'h00000001, 32'h80000000, 1'b1, 4'b1000}, // R6
        {3'd1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 4'b0011},
        {3'd5, 32'h00000003, 32'h00000001, 32'h00000001, 1'b1, 4'b0011}, // R6 V kept
        {3'd5, 32'h00000002, 32'h00000001, 32'h00000001, 1'b1, 4'b0001}, // R6
        {3'd0, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, 1'b1, 4'b0010},
        {3'd4, 32'h00000005, 32'h00000000, 32'h00000005, 1'b1, 4'b0010}, // R6 amt 0
        {3'd4, 32'h80000000, 32'h00000001, 32'h00000000, 1'b1, 4'b0110}, // R6
        {3'd2, 32'h00000003, 32'h00000005, 32'h00000000, 1'b0, 4'b1000}, // R5
        {3'd5, 32'h80000000, 32'h0000001F, 32'h00000001, 1'b1, 4'b0000}, // R6
        {3'd1, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 4'b0110}  // R2
    };

    function automatic logic exp_br(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0: return z;          4'd1: return !z;
            4'd2: return cy;         4'd3: return !cy;
            4'd4: return n;          4'd5: return !n;
            4'd6: return v;          4'd7: return !v;
            4'd8: return cy && !z;   4'd9: return !cy || z;
            4'd10: return n == v;    4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Sweep all condition codes against a known stored flag value (R9, R10).
    task automatic sweep_conds(input logic [3:0] f, input string req);
        for (int c = 0; c < 16; c++) begin
            cond = 4'(c);
            #1;
            check(br_taken == exp_br(4'(c), f), req, {31'd0, br_taken},
                  {31'd0, exp_br(4'(c), f)});
        end
    endtask

    // Apply one operation at the falling edge, check result, then flags after the edge.
    task automatic apply(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sf, input logic [31:0] er, input logic ew,
                         input logic [3:0] ef, input string req);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; set_flags = sf;
        #2;
        check(result == er, req, result, er);
        check(result_wr == ew, req, {31'd0, result_wr}, {31'd0, ew});
        @(posedge clk);
        #1;
        check(nzcv == ef, req, {28'd0, nzcv}, {28'd0, ef});
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(nzcv == 4'b0000, "R7 reset", {28'd0, nzcv}, 32'd0);
        sweep_conds(4'b0000, "R9 after reset");

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][103:101], VECS[i][100:69], VECS[i][68:37], 1'b1,
                  VECS[i][36:5], VECS[i][4], VECS[i][3:0], "R1-vector");
            sweep_conds(VECS[i][3:0], "R9 vector");
        end

        // R7: no flag update without set_flags; R10: branch ignores current op
        apply(3'd0, 32'h7FFFFFFF, 32'h1, 1'b0, 32'h80000000, 1'b1, 4'b0110, "R7 hold");
        @(negedge clk);
        op_sel = 3'd1; opnd_a = 32'd1; opnd_b = 32'd2; set_flags = 1'b0;
        sweep_conds(4'b0110, "R10 stored flags");

        // R8: no-op codes keep flags even with set_flags
        apply(3'd6, 32'h0, 32'h0, 1'b1, 32'h0, 1'b0, 4'b0110, "R8 op6");
        apply(3'd7, 32'h80000000, 32'h1, 1'b1, 32'h0, 1'b0, 4'b0110, "R8 op7");

        // R7: synchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0; set_flags = 1'b0;
        @(posedge clk);
        #1;
        check(nzcv == 4'b0000, "R7 mid reset", {28'd0, nzcv}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule